// File: doc/BRIEF.md
# Address Translation Window Bank

This block keeps a bank of programmable address windows for a PCIe root port, with one set of windows for inbound traffic and one for outbound traffic. Software programs the windows through a narrow 32-bit register port. A select register picks one window, and the other registers then read and write that window only. A window's geometry is staged first and only takes effect when its enable word is written. Software can therefore rewrite a live window's fields without the lookup path seeing a half-updated window.

A lookup port takes an address and a direction. One clock later it reports whether a window matched and which one did. It also gives the translated address. For an outbound window of configuration type, the result instead carries the bus number and the device/function number taken from the window's target. A lookup that matches no window returns an all-ones address.

Top module: `xw_window_bank`

## Requirements
- R1: Writing the select register (word 0, byte offset 0x00) stores the window index from data bits [3:0] and the direction from bit 31 (1 = inbound, 0 = outbound). Reading it returns the direction in bit 31, the index in bits [3:0] and zeros elsewhere.
- R2: Word offsets 1..7 (byte 0x04..0x1C) act on the selected window. They are: base low, base high, limit (32 bit), target low, target high, kind, and arm. A write to a low or high half replaces only that 32-bit half. A read returns the value stored for the selected window.
- R3: The base, limit, kind and enable used by lookups change only when the arm word is written. Arm bit 31 is the enable. Writes to the other window registers have no effect on lookups until then.
- R4: A window matches when it is enabled and base <= address <= {base[63:32], limit}, with both bounds inclusive.
- R5: When several windows of the looked-up direction match, the lowest index wins and is reported on res_win.
- R6: A memory-type match returns target + (address - base). The target used is the value currently stored, not the value captured at arm time.
- R7: An outbound window armed while its kind word was non-zero is a configuration window. A match on it sets res_cfg and returns address - base, with bus = target[31:24] and devfn = target[23:16]. Inbound windows always translate as memory.
- R8: On a miss, res_hit and res_cfg are 0, res_addr is all ones, and res_bus, res_devfn and res_win are 0.
- R9: After reset every window has base 0, target 0, limit 0xFFFFFFFF, kind 0 and arm 0. The one exception is inbound window 0, which has arm 0x80000000 and is live, so it passes inbound addresses 0..0xFFFFFFFF unchanged.
- R10: A result appears on the outputs one clock after the lookup is presented. res_valid follows lk_valid with that delay. While res_valid is 0 the outputs hold the miss values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset; bits [4:2] select the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_cfg | output | 1 | Match was on a configuration window |
| res_win | output | 4 | Index of the matching window |
| res_addr | output | 64 | Translated address or offset; all ones on a miss |
| res_bus | output | 8 | Bus number for a configuration match |
| res_devfn | output | 8 | Device/function for a configuration match |

## Verification
The bench targets the exact window edges: limit inclusive, one past the limit, one below the base, and an address above the 4 GiB limit of the reset window. An off-by-one compare would turn one of these hits into a miss, or a miss into a hit. The bench changes the staged base and then looks up before arming. A design that applies fields at write time would move the window early. Overlapping windows show whether priority goes to the lowest index. A configuration-kind inbound window and a configuration outbound window check that the kind only matters outbound. They also check that bus and devfn come from the right target bits. Disarming the reset inbound window must turn its hits into all-ones misses.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int XW_AW = 64;
    localparam int XW_DW = 32;

    // register word indices (byte offset = word * 4)
    localparam logic [2:0] W_SEL    = 3'd0;
    localparam logic [2:0] W_BASE_L = 3'd1;
    localparam logic [2:0] W_BASE_H = 3'd2;
    localparam logic [2:0] W_LIMIT  = 3'd3;
    localparam logic [2:0] W_TGT_L  = 3'd4;
    localparam logic [2:0] W_TGT_H  = 3'd5;
    localparam logic [2:0] W_KIND   = 3'd6;
    localparam logic [2:0] W_ARM    = 3'd7;

    localparam int ARM_EN_BIT = 31;

    typedef struct packed {
        logic [XW_AW-1:0] base;
        logic [XW_DW-1:0] limit;
        logic [XW_AW-1:0] target;
        logic [XW_DW-1:0] kind;
        logic [XW_DW-1:0] arm;
    } win_stage_t;

    typedef struct packed {
        logic [XW_AW-1:0] base;
        logic [XW_DW-1:0] limit;
        logic             is_cfg;
        logic             en;
    } win_live_t;
endpackage

// File: rtl/xw_regfile.sv
module xw_regfile
    import xw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [4:0]                          addr,
    input  logic [XW_DW-1:0]                    wdata,
    output logic [XW_DW-1:0]                    rdata,
    output win_live_t [2*(1<<IDX_W)-1:0]        live_o,
    output logic [2*(1<<IDX_W)-1:0][XW_AW-1:0]  tgt_o
);
    localparam int NWIN  = 1 << IDX_W;
    localparam int NSLOT = 2 * NWIN;

    typedef struct packed {
        logic                   dir;
        logic [IDX_W-1:0]       idx;
        win_stage_t [NSLOT-1:0] stg;
        win_live_t  [NSLOT-1:0] live;
    } rf_state_t;

    rf_state_t st_q, st_d;

    function automatic rf_state_t rf_reset();
        rf_state_t r;
        r.dir = 1'b0;
        r.idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            r.stg[i].base   = '0;
            r.stg[i].limit  = '1;
            r.stg[i].target = '0;
            r.stg[i].kind   = '0;
            r.stg[i].arm    = '0;
            r.live[i].base  = '0;
            r.live[i].limit = '1;
            r.live[i].is_cfg = 1'b0;
            r.live[i].en    = 1'b0;
        end
        // inbound window 0 passes everything below 4 GiB
        r.stg[NWIN].arm[ARM_EN_BIT] = 1'b1;
        r.live[NWIN].en             = 1'b1;
        return r;
    endfunction

    logic [2:0]       word;
    logic [IDX_W:0]   slot;

    assign word = addr[4:2];
    assign slot = {st_q.dir, st_q.idx};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (word)
                W_SEL: begin
                    st_d.dir = wdata[31];
                    st_d.idx = wdata[IDX_W-1:0];
                end
                W_BASE_L: st_d.stg[slot].base[31:0]    = wdata;
                W_BASE_H: st_d.stg[slot].base[63:32]   = wdata;
                W_LIMIT:  st_d.stg[slot].limit         = wdata;
                W_TGT_L:  st_d.stg[slot].target[31:0]  = wdata;
                W_TGT_H:  st_d.stg[slot].target[63:32] = wdata;
                W_KIND:   st_d.stg[slot].kind          = wdata;
                W_ARM: begin
                    st_d.stg[slot].arm     = wdata;
                    st_d.live[slot].base   = st_q.stg[slot].base;
                    st_d.live[slot].limit  = st_q.stg[slot].limit;
                    st_d.live[slot].is_cfg = |st_q.stg[slot].kind;
                    st_d.live[slot].en     = wdata[ARM_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rf_reset();
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (word)
            W_SEL:    rdata = {st_q.dir, {(31-IDX_W){1'b0}}, st_q.idx};
            W_BASE_L: rdata = st_q.stg[slot].base[31:0];
            W_BASE_H: rdata = st_q.stg[slot].base[63:32];
            W_LIMIT:  rdata = st_q.stg[slot].limit;
            W_TGT_L:  rdata = st_q.stg[slot].target[31:0];
            W_TGT_H:  rdata = st_q.stg[slot].target[63:32];
            W_KIND:   rdata = st_q.stg[slot].kind;
            W_ARM:    rdata = st_q.stg[slot].arm;
            default:  rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_out
        assign live_o[g] = st_q.live[g];
        assign tgt_o[g]  = st_q.stg[g].target;
    end
endmodule

// File: rtl/xw_match.sv
module xw_match
    import xw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                          dir,
    input  logic [XW_AW-1:0]              addr,
    input  win_live_t [2*(1<<IDX_W)-1:0]  live_i,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx
);
    localparam int NWIN = 1 << IDX_W;

    logic [NWIN-1:0] hit_vec;

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        localparam int OUT_SLOT = g;
        localparam int IN_SLOT  = NWIN + g;
        win_live_t        w;
        logic [XW_AW-1:0] upper;
        assign w       = dir ? live_i[IN_SLOT] : live_i[OUT_SLOT];
        assign upper   = {w.base[63:32], w.limit};
        assign hit_vec[g] = w.en && (addr >= w.base) && (addr <= upper);
    end

    always_comb begin
        found   = |hit_vec;
        win_idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/xw_result.sv
module xw_result
    import xw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_inbound,
    input  logic [XW_AW-1:0]  lk_addr,
    input  logic              found,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [XW_AW-1:0]  w_base,
    input  logic              w_cfg,
    input  logic [XW_AW-1:0]  w_target,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_cfg,
    output logic [IDX_W-1:0]  res_win,
    output logic [XW_AW-1:0]  res_addr,
    output logic [7:0]        res_bus,
    output logic [7:0]        res_devfn
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             cfg;
        logic [IDX_W-1:0] win;
        logic [XW_AW-1:0] addr;
        logic [7:0]       bus;
        logic [7:0]       devfn;
    } res_t;

    localparam res_t RES_IDLE = '{valid: 1'b0, hit: 1'b0, cfg: 1'b0, win: '0,
                                  addr: '1, bus: 8'h00, devfn: 8'h00};

    res_t             r_q, r_d;
    logic [XW_AW-1:0] offset;

    assign offset = lk_addr - w_base;

    always_comb begin
        r_d       = RES_IDLE;
        r_d.valid = lk_valid;
        if (lk_valid && found) begin
            r_d.hit = 1'b1;
            r_d.win = win_idx;
            if (w_cfg && !lk_inbound) begin
                r_d.cfg   = 1'b1;
                r_d.addr  = offset;
                r_d.bus   = w_target[31:24];
                r_d.devfn = w_target[23:16];
            end else begin
                r_d.addr  = w_target + offset;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RES_IDLE;
        else        r_q <= r_d;
    end

    assign res_valid = r_q.valid;
    assign res_hit   = r_q.hit;
    assign res_cfg   = r_q.cfg;
    assign res_win   = r_q.win;
    assign res_addr  = r_q.addr;
    assign res_bus   = r_q.bus;
    assign res_devfn = r_q.devfn;
endmodule

// File: rtl/xw_window_bank.sv
module xw_window_bank
    import xw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic              lk_inbound,
    input  logic [63:0]       lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_cfg,
    output logic [IDX_W-1:0]  res_win,
    output logic [63:0]       res_addr,
    output logic [7:0]        res_bus,
    output logic [7:0]        res_devfn
);
    localparam int NSLOT = 2 * (1 << IDX_W);

    win_live_t [NSLOT-1:0]             live;
    logic [NSLOT-1:0][XW_AW-1:0]       tgt;
    logic                              found;
    logic [IDX_W-1:0]                  win_idx;
    logic [IDX_W:0]                    sel_slot;
    win_live_t                         w_sel;

    xw_regfile #(.IDX_W(IDX_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .live_o (live),
        .tgt_o  (tgt)
    );

    xw_match #(.IDX_W(IDX_W)) u_match (
        .dir     (lk_inbound),
        .addr    (lk_addr),
        .live_i  (live),
        .found   (found),
        .win_idx (win_idx)
    );

    assign sel_slot = {lk_inbound, win_idx};
    assign w_sel    = live[sel_slot];

    xw_result #(.IDX_W(IDX_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_inbound (lk_inbound),
        .lk_addr    (lk_addr),
        .found      (found),
        .win_idx    (win_idx),
        .w_base     (w_sel.base),
        .w_cfg      (w_sel.is_cfg),
        .w_target   (tgt[sel_slot]),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_cfg    (res_cfg),
        .res_win    (res_win),
        .res_addr   (res_addr),
        .res_bus    (res_bus),
        .res_devfn  (res_devfn)
    );
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [4:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              lk_valid,
    input logic              lk_inbound,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_cfg,
    input logic [63:0]       res_addr
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (res_valid == $past(lk_valid)));

    p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_hit);

    p_miss_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '1 && !res_cfg));

    p_cfg_outbound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && res_cfg) |-> !$past(lk_inbound));

    p_sel_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && reg_addr[4:2] == 3'd0 && $past(reg_wr_en && reg_addr[4:2] == 3'd0))
        |-> (reg_rdata == {$past(reg_wdata[31]), {(31-IDX_W){1'b0}},
                           $past(reg_wdata[IDX_W-1:0])}));
endmodule

bind xw_window_bank xw_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .lk_valid   (lk_valid),
    .lk_inbound (lk_inbound),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_cfg    (res_cfg),
    .res_addr   (res_addr)
);

// File: tb/xw_window_bank_test.sv
module xw_window_bank_test;
    localparam int NW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, reg_wr_en, lk_valid, lk_inbound;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [63:0] lk_addr, res_addr;
    logic        res_valid, res_hit, res_cfg;
    logic [3:0]  res_win;
    logic [7:0]  res_bus, res_devfn;

    xw_window_bank uut (.*);

    int errors = 0;
    int checks = 0;

    // behavioural model
    logic [63:0] m_base [2*NW], m_tgt [2*NW], a_base [2*NW];
    logic [31:0] m_lim [2*NW], m_kind [2*NW], m_arm [2*NW], a_lim [2*NW];
    bit          a_cfg [2*NW], a_en [2*NW];
    bit          m_dir;
    int          m_idx;

    logic [86:0] exp_res;
    string       exp_tag;

    function automatic int cur();
        return (m_dir ? NW : 0) + m_idx;
    endfunction

    function automatic logic [31:0] mdl_read(logic [4:0] a);
        case (a[4:2])
            3'd0: return {m_dir, 27'd0, m_idx[3:0]};
            3'd1: return m_base[cur()][31:0];
            3'd2: return m_base[cur()][63:32];
            3'd3: return m_lim[cur()];
            3'd4: return m_tgt[cur()][31:0];
            3'd5: return m_tgt[cur()][63:32];
            3'd6: return m_kind[cur()];
            default: return m_arm[cur()];
        endcase
    endfunction

    function automatic logic [86:0] mdl_lookup(bit v, bit inb, logic [63:0] a);
        logic [63:0] off;
        if (!v) return {3'b000, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0};
        for (int i = 0; i < NW; i++) begin
            int s = (inb ? NW : 0) + i;
            if (a_en[s] && a >= a_base[s] && a <= {a_base[s][63:32], a_lim[s]}) begin
                off = a - a_base[s];
                if (a_cfg[s] && !inb)
                    return {3'b111, i[3:0], off, m_tgt[s][31:24], m_tgt[s][23:16]};
                return {3'b110, i[3:0], m_tgt[s] + off, 16'd0};
            end
        end
        return {3'b100, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0};
    endfunction

    task automatic mdl_write(logic [4:0] a, logic [31:0] d);
        int s = cur();
        case (a[4:2])
            3'd0: begin m_dir = d[31]; m_idx = int'(d[3:0]); end
            3'd1: m_base[s][31:0]  = d;
            3'd2: m_base[s][63:32] = d;
            3'd3: m_lim[s]         = d;
            3'd4: m_tgt[s][31:0]   = d;
            3'd5: m_tgt[s][63:32]  = d;
            3'd6: m_kind[s]        = d;
            default: begin
                m_arm[s] = d; a_base[s] = m_base[s]; a_lim[s] = m_lim[s];
                a_cfg[s] = (m_kind[s] != 0); a_en[s] = d[31];
            end
        endcase
    endtask

    task automatic check_res();
        logic [86:0] got;
        got = {res_valid, res_hit, res_cfg, res_win, res_addr, res_bus, res_devfn};
        checks++;
        if (got !== exp_res) begin
            errors++;
            $display("FAIL %s result got %h expected %h", exp_tag, got, exp_res);
        end
    endtask

    task automatic cyc(bit wr, logic [4:0] a, logic [31:0] d, bit lv, bit li,
                       logic [63:0] la, string rtag, string ltag);
        logic [31:0] er;
        @(negedge clk);
        check_res();
        reg_wr_en = wr; reg_addr = a; reg_wdata = d;
        lk_valid = lv; lk_inbound = li; lk_addr = la;
        #1;
        er = mdl_read(a);
        checks++;
        if (reg_rdata !== er) begin
            errors++;
            $display("FAIL %s readback @%h got %h expected %h", rtag, a, reg_rdata, er);
        end
        exp_res = mdl_lookup(lv, li, la);
        exp_tag = ltag;
        @(posedge clk);
        if (wr) mdl_write(a, d);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d, string t);
        cyc(1, a, d, 0, 0, 64'd0, t, "R10");
    endtask
    task automatic rd(logic [4:0] a, string t);
        cyc(0, a, 32'd0, 0, 0, 64'd0, t, "R10");
    endtask
    task automatic look(bit inb, logic [63:0] la, string t);
        cyc(0, 5'h00, 32'd0, 1, inb, la, "R1", t);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired got running expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2*NW; i++) begin
            m_base[i] = 0; m_tgt[i] = 0; m_lim[i] = 32'hFFFF_FFFF; m_kind[i] = 0;
            m_arm[i] = 0; a_base[i] = 0; a_lim[i] = 32'hFFFF_FFFF; a_cfg[i] = 0; a_en[i] = 0;
        end
        m_arm[NW] = 32'h8000_0000; a_en[NW] = 1;
        m_dir = 0; m_idx = 0;
        exp_res = mdl_lookup(0, 0, 0); exp_tag = "R9";
        rst_n = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
        lk_valid = 0; lk_inbound = 0; lk_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R9 reset contents and default inbound window
        rd(5'h0C, "R9");
        rd(5'h1C, "R9");
        look(1, 64'h0000_0000_0000_1234, "R9");
        look(1, 64'h0000_0000_FFFF_FFFF, "R9");
        look(1, 64'h0000_0001_0000_0000, "R8");
        look(0, 64'h0000_0000_0000_1234, "R9");

        // R1 select outbound 3, R2 program it
        wr(5'h00, 32'h0000_0003, "R1");
        rd(5'h00, "R1");
        wr(5'h04, 32'h0000_1000, "R2");
        wr(5'h08, 32'h0000_0000, "R2");
        wr(5'h0C, 32'h0000_1FFF, "R2");
        wr(5'h10, 32'h8000_0000, "R2");
        wr(5'h14, 32'h0000_0001, "R2");
        look(0, 64'h1800, "R3");
        wr(5'h1C, 32'h8000_0000, "R3");
        look(0, 64'h1800, "R6");
        look(0, 64'h1FFF, "R4");
        look(0, 64'h2000, "R4");
        look(0, 64'h0FFF, "R4");
        look(0, 64'h1000, "R4");

        // R2 half replace; R3 staged base not yet live
        wr(5'h08, 32'h0000_0002, "R2");
        rd(5'h04, "R2");
        rd(5'h08, "R2");
        look(0, 64'h1800, "R3");
        wr(5'h08, 32'h0000_0000, "R2");
        // R6 target change is used without re-arming
        wr(5'h10, 32'h4000_0000, "R6");
        look(0, 64'h1800, "R6");

        // R5 overlapping outbound window 1
        wr(5'h00, 32'h0000_0001, "R1");
        wr(5'h04, 32'h0000_1000, "R2");
        wr(5'h0C, 32'h0000_17FF, "R2");
        wr(5'h1C, 32'h8000_0000, "R3");
        look(0, 64'h1100, "R5");
        look(0, 64'h1900, "R5");

        // R7 config window outbound 5
        wr(5'h00, 32'h0000_0005, "R1");
        wr(5'h04, 32'h4000_0000, "R2");
        wr(5'h0C, 32'h4FFF_FFFF, "R2");
        wr(5'h10, 32'h0A18_0000, "R2");
        wr(5'h18, 32'h0000_0004, "R2");
        wr(5'h1C, 32'h8000_0000, "R3");
        look(0, 64'h4000_0123, "R7");

        // R7 inbound kind ignored; upper-base window
        wr(5'h00, 32'h8000_0002, "R1");
        rd(5'h00, "R1");
        wr(5'h08, 32'h0000_0002, "R2");
        wr(5'h0C, 32'h0000_FFFF, "R2");
        wr(5'h10, 32'h0000_0100, "R2");
        wr(5'h18, 32'h0000_0004, "R2");
        wr(5'h1C, 32'h8000_0000, "R3");
        look(1, 64'h0000_0002_0000_0010, "R7");
        look(1, 64'h0000_0002_0001_0000, "R4");

        // R3 disarm inbound 0, R8 miss
        wr(5'h00, 32'h8000_0000, "R1");
        wr(5'h1C, 32'h0000_0000, "R3");
        look(1, 64'h10, "R8");
        rd(5'h1C, "R3");
        rd(5'h00, "R10");

        @(negedge clk);
        check_res();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule